// File: doc/BRIEF.md
# Nonce Sweep and Difficulty Checker

This block drives a fixed-latency double-hash pipeline. It does not contain that pipeline. A host loads a 256-bit prefix digest and a required zero count while the block is idle. On each following cycle the block presents one pipeline input: the prefix joined with a counter in the low bits. The counter advances by one per cycle until it has covered its whole range.

A delay line as deep as the pipeline latency carries each issued counter value and a valid flag. Each hash that comes back from the pipeline is therefore paired with the counter that produced it. A result passes when its top bits hold at least the required number of zeros. Only a fixed window of upper bits is examined. On a pass the block raises an alert carrying the winning counter value, and holds it until the host acknowledges it.

When the result for the final counter value has returned, the block raises a done flag and goes idle. The host can then supply a fresh prefix.

Top module: `nonce_sweep_top`

## Requirements
- R1: While reset is high and on the cycle after it, `busy`, `done`, `alert` and `pipe_in_valid` are low.
- R2: A load presented while `busy` is low is taken at that clock edge. On the next cycle `busy` is high, `done` is low, `pipe_in_valid` is high and `pipe_in_data` equals {prefix, counter 0}, with the prefix in the upper 256 bits and the counter in the low CNT_W bits.
- R3: While `pipe_in_valid` is high, the counter field rises by exactly one per cycle. After the cycle that shows the all-ones counter, `pipe_in_valid` falls, so a sweep issues exactly 2^CNT_W inputs.
- R4: A load presented while `busy` is high is ignored: the prefix field and the counter progression are unchanged.
- R5: The hash on `pipe_out_hash` in cycle c+LATENCY belongs to the input issued in cycle c. An alert for that input is visible in cycle c+LATENCY+1.
- R6: A result passes when its leading-zero count, taken over the top 66 bits only, is at least the stored zero count. Bits below the top 66 never affect the test.
- R7: A loaded zero count of 0 is stored as 1, and any value above 66 is stored as 66.
- R8: A passing result raises `alert` and captures its counter in `alert_nonce`. While `alert` is high and `alert_ack` is low, both stay unchanged and later passing results are dropped.
- R9: `alert_ack` clears `alert` at the next edge. If a passing result arrives in the same cycle as the acknowledge, that result is captured instead, so acknowledging every cycle the alert is seen loses no hit.
- R10: `done` rises, and `busy` falls, in the cycle after the result for the all-ones counter returns, which is 2^CNT_W + LATENCY + 1 cycles after the load edge. `done` stays high until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Host request to start a sweep |
| load_prefix | input | 256 | Prefix digest for the sweep |
| load_zeros | input | 7 | Required leading-zero count |
| busy | output | 1 | Sweep issuing or results in flight |
| done | output | 1 | Last result of the sweep has returned |
| pipe_in_valid | output | 1 | Pipeline input is valid this cycle |
| pipe_in_data | output | 256+CNT_W | {prefix, counter} seed to the pipeline |
| pipe_out_hash | input | 256 | Hash returning from the pipeline |
| alert_ack | input | 1 | Host acknowledge of the held alert |
| alert | output | 1 | A passing result is held |
| alert_nonce | output | CNT_W | Counter value of the held result |

## Verification
The timing of each result is fixed. A load taken at edge E shows counter 0 at the next sample. The alert for counter n is due LATENCY+2+n sampled cycles after E. `done` is due exactly 2^CNT_W+LATENCY+1 samples after E. The bench counts sampled cycles from the load edge and compares the first alert and the done rise against those exact counts, not against a window. In the table-driven sweeps the bench acknowledges on the cycle after each alert appears, so back-to-back passing results must each be seen once. The total is compared with the count worked out from the hash model.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    // Digest width carried through the sweep and back from the pipeline.
    localparam int HASH_W    = 256;
    // Upper bits examined by the difficulty test; also the largest legal count.
    localparam int MAX_ZEROS = 66;
    // Width of the stored zero count.
    localparam int ZW        = $clog2(MAX_ZEROS + 1);

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_ISSUE = 2'd1,
        SW_DRAIN = 2'd2
    } sweep_state_e;

    // Force a requested zero count into the legal range 1..MAX_ZEROS.
    function automatic logic [ZW-1:0] clamp_zeros(input logic [ZW-1:0] z);
        if (z == '0) begin
            return ZW'(1);
        end else if (z > ZW'(MAX_ZEROS)) begin
            return ZW'(MAX_ZEROS);
        end else begin
            return z;
        end
    endfunction

    // Count zeros from the top of the window down to the first set bit.
    function automatic logic [ZW-1:0] lead_zeros(input logic [MAX_ZEROS-1:0] v);
        logic [ZW-1:0] n;
        logic          run;
        n   = '0;
        run = 1'b1;
        for (int i = MAX_ZEROS - 1; i >= 0; i--) begin
            if (v[i]) begin
                run = 1'b0;
            end
            if (run) begin
                n = n + ZW'(1);
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/nsc_issue.sv
module nsc_issue
    import nsc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_valid,
    input  logic [HASH_W-1:0] load_prefix,
    input  logic [ZW-1:0]     load_zeros,
    input  logic              last_back,
    output logic [HASH_W-1:0] prefix_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              issue_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ZW-1:0]     zeros_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    sweep_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SW_IDLE;
            prefix_o <= '0;
            cnt_o    <= '0;
            issue_o  <= 1'b0;
            done_o   <= 1'b0;
            zeros_o  <= ZW'(1);
        end else begin
            case (state_q)
                SW_IDLE: begin
                    if (load_valid) begin
                        prefix_o <= load_prefix;
                        zeros_o  <= clamp_zeros(load_zeros);
                        cnt_o    <= '0;
                        issue_o  <= 1'b1;
                        done_o   <= 1'b0;
                        state_q  <= SW_ISSUE;
                    end
                end
                SW_ISSUE: begin
                    if (cnt_o == CNT_LAST) begin
                        issue_o <= 1'b0;
                        state_q <= SW_DRAIN;
                    end else begin
                        cnt_o <= cnt_o + CNT_W'(1);
                    end
                end
                SW_DRAIN: begin
                    if (last_back) begin
                        done_o  <= 1'b1;
                        state_q <= SW_IDLE;
                    end
                end
                default: begin
                    state_q <= SW_IDLE;
                end
            endcase
        end
    end

    assign busy_o = (state_q != SW_IDLE);

endmodule

// File: rtl/nsc_delay.sv
module nsc_delay #(
    parameter int W     = 33,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);

    logic         v_q [DEPTH];
    logic [W-1:0] d_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q[s] <= 1'b0;
                end else begin
                    v_q[s] <= in_v;
                end
                d_q[s] <= in_d;
            end
        end else begin : g_link
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q[s] <= 1'b0;
                end else begin
                    v_q[s] <= v_q[s-1];
                end
                d_q[s] <= d_q[s-1];
            end
        end
    end

    assign out_v = v_q[DEPTH-1];
    assign out_d = d_q[DEPTH-1];

endmodule

// File: rtl/nsc_zero_test.sv
module nsc_zero_test
    import nsc_pkg::*;
(
    input  logic [HASH_W-1:0] hash_i,
    input  logic [ZW-1:0]     zeros_i,
    output logic              pass_o
);

    logic [MAX_ZEROS-1:0] window;
    logic [ZW-1:0]        run_len;

    always_comb begin
        window  = hash_i[HASH_W-1 -: MAX_ZEROS];
        run_len = lead_zeros(window);
        pass_o  = (run_len >= zeros_i);
    end

endmodule

// File: rtl/nsc_alert.sv
module nsc_alert #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] nonce_i,
    input  logic             ack_i,
    output logic             alert_o,
    output logic [CNT_W-1:0] nonce_o
);

    logic can_take;

    assign can_take = !alert_o || ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            alert_o <= 1'b0;
            nonce_o <= '0;
        end else if (hit_i && can_take) begin
            alert_o <= 1'b1;
            nonce_o <= nonce_i;
        end else if (ack_i) begin
            alert_o <= 1'b0;
        end
    end

endmodule

// File: rtl/nonce_sweep_top.sv
module nonce_sweep_top
    import nsc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int LATENCY = 128
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_valid,
    input  logic [HASH_W-1:0]       load_prefix,
    input  logic [ZW-1:0]           load_zeros,
    output logic                    busy,
    output logic                    done,
    output logic                    pipe_in_valid,
    output logic [HASH_W+CNT_W-1:0] pipe_in_data,
    input  logic [HASH_W-1:0]       pipe_out_hash,
    input  logic                    alert_ack,
    output logic                    alert,
    output logic [CNT_W-1:0]        alert_nonce
);

    localparam int TAG_W = CNT_W;
    localparam logic [TAG_W-1:0] TAG_LAST = {TAG_W{1'b1}};

    logic [HASH_W-1:0] prefix_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ZW-1:0]     zeros_q;
    logic              back_v;
    logic [TAG_W-1:0]  back_n;
    logic              last_back;
    logic              pass_w;
    logic              hit_w;

    nsc_issue #(.CNT_W(CNT_W)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_prefix(load_prefix),
        .load_zeros (load_zeros),
        .last_back  (last_back),
        .prefix_o   (prefix_q),
        .cnt_o      (cnt_q),
        .issue_o    (pipe_in_valid),
        .busy_o     (busy),
        .done_o     (done),
        .zeros_o    (zeros_q)
    );

    nsc_delay #(.W(TAG_W), .DEPTH(LATENCY)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .in_v (pipe_in_valid),
        .in_d (cnt_q),
        .out_v(back_v),
        .out_d(back_n)
    );

    nsc_zero_test u_zero (
        .hash_i (pipe_out_hash),
        .zeros_i(zeros_q),
        .pass_o (pass_w)
    );

    assign hit_w     = back_v && pass_w;
    assign last_back = back_v && (back_n == TAG_LAST);

    nsc_alert #(.CNT_W(CNT_W)) u_alert (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit_w),
        .nonce_i(back_n),
        .ack_i  (alert_ack),
        .alert_o(alert),
        .nonce_o(alert_nonce)
    );

    assign pipe_in_data = {prefix_q, cnt_q};

endmodule

// File: rtl/nonce_sweep_chk.sv
module nonce_sweep_chk
    import nsc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load_valid,
    input logic                    busy,
    input logic                    done,
    input logic                    pipe_in_valid,
    input logic [HASH_W+CNT_W-1:0] pipe_in_data,
    input logic                    alert,
    input logic [CNT_W-1:0]        alert_nonce,
    input logic                    alert_ack,
    input logic                    hit
);

    logic [CNT_W-1:0]  nonce_f;
    logic [HASH_W-1:0] prefix_f;

    assign nonce_f  = pipe_in_data[CNT_W-1:0];
    assign prefix_f = pipe_in_data[HASH_W+CNT_W-1 -: HASH_W];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !busy && !done && !alert && !pipe_in_valid); // R1

    AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
        load_valid && !busy |=> pipe_in_valid && busy && !done && (nonce_f == '0)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        pipe_in_valid && $past(pipe_in_valid) |-> nonce_f == $past(nonce_f) + CNT_W'(1)); // R3

    AST_PREFIX_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(prefix_f)); // R4

    AST_HIT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        hit && (!alert || alert_ack) |=> alert); // R8

    AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (rst)
        alert && !alert_ack |=> alert && $stable(alert_nonce)); // R8

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        alert_ack && !hit |=> !alert); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !pipe_in_valid); // R10

endmodule

bind nonce_sweep_top nonce_sweep_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_valid   (load_valid),
    .busy         (busy),
    .done         (done),
    .pipe_in_valid(pipe_in_valid),
    .pipe_in_data (pipe_in_data),
    .alert        (alert),
    .alert_nonce  (alert_nonce),
    .alert_ack    (alert_ack),
    .hit          (hit_w)
);

// File: tb/nonce_sweep_top_tb.sv
module nonce_sweep_top_tb;
    import nsc_pkg::*;

    localparam int TB_CNT = 6;
    localparam int TB_LAT = 5;
    localparam int DW     = HASH_W + TB_CNT;
    localparam int DONE_AT = (1 << TB_CNT) + TB_LAT + 1;
    localparam int NVEC   = 10;
    // columns: zero-bit offset k, requested zeros, expected hits, expected first nonce, clamp case
    localparam int VEC [NVEC][5] = '{
        '{0,  1,   32, 0, 0},
        '{3,  6,   1,  0, 0},
        '{3,  9,   1,  0, 0},
        '{3,  10,  0,  0, 0},
        '{60, 66,  1,  0, 0},
        '{59, 66,  0,  0, 0},
        '{0,  0,   32, 0, 1},
        '{60, 100, 1,  0, 1},
        '{0,  4,   4,  0, 0},
        '{0,  3,   8,  0, 0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic              load_valid;
    logic [HASH_W-1:0] load_prefix;
    logic [ZW-1:0]     load_zeros;
    logic              busy, done, pipe_in_valid, alert, alert_ack;
    logic [DW-1:0]     pipe_in_data;
    logic [HASH_W-1:0] pipe_out_hash;
    logic [TB_CNT-1:0] alert_nonce;

    int checks = 0;
    int fails  = 0;

    nonce_sweep_top #(.CNT_W(TB_CNT), .LATENCY(TB_LAT)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .load_valid   (load_valid),
        .load_prefix  (load_prefix),
        .load_zeros   (load_zeros),
        .busy         (busy),
        .done         (done),
        .pipe_in_valid(pipe_in_valid),
        .pipe_in_data (pipe_in_data),
        .pipe_out_hash(pipe_out_hash),
        .alert_ack    (alert_ack),
        .alert        (alert),
        .alert_nonce  (alert_nonce)
    );

    // Stand-in pipeline: TB_LAT registers, hash = prefix with the nonce folded into its top bits.
    logic [DW-1:0] model_q [TB_LAT];
    always_ff @(posedge clk) begin
        model_q[0] <= pipe_in_data;
        for (int i = 1; i < TB_LAT; i++) begin
            model_q[i] <= model_q[i-1];
        end
    end
    assign pipe_out_hash = model_q[TB_LAT-1][DW-1:TB_CNT]
                         ^ {model_q[TB_LAT-1][TB_CNT-1:0], {(HASH_W-TB_CNT){1'b0}}};

    function automatic logic [HASH_W-1:0] mk_prefix(input int k);
        return {{(HASH_W-1){1'b0}}, 1'b1} << (HASH_W - 1 - TB_CNT - k);
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_load(input logic [HASH_W-1:0] p, input logic [ZW-1:0] z);
        @(negedge clk);
        load_prefix = p;
        load_zeros  = z;
        load_valid  = 1'b1;
        @(posedge clk);
        #1 load_valid = 1'b0;
    endtask

    task automatic run_vec(input int k, input int z, output int hits, output int first);
        int guard;
        hits  = 0;
        first = -1;
        guard = 0;
        start_load(mk_prefix(k), ZW'(z));
        forever begin
            @(negedge clk);
            guard++;
            alert_ack = 1'b0;
            if (alert) begin
                if (hits == 0) first = int'(alert_nonce);
                hits++;
                alert_ack = 1'b1;
            end
            if (done || guard > 1000) break;
        end
        @(negedge clk);
        alert_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        load_valid  = 1'b0;
        load_prefix = '0;
        load_zeros  = '0;
        alert_ack   = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        chk(!busy && !done && !alert && !pipe_in_valid, "R1 reset state",
            {busy, done, alert, pipe_in_valid}, 0);

        // Table of sweeps, host acknowledges each alert as soon as it is seen.
        for (int v = 0; v < NVEC; v++) begin
            int hits, first;
            run_vec(VEC[v][0], VEC[v][1], hits, first);
            if (VEC[v][4] != 0)
                chk(hits == VEC[v][2], "R7 clamped count hits", hits, VEC[v][2]);
            else
                chk(hits == VEC[v][2], "R6,R9 hit count", hits, VEC[v][2]);
            if (VEC[v][2] > 0)
                chk(first == VEC[v][3], "R5 first nonce", first, VEC[v][3]);
        end

        // Directed sweep without acknowledge: timing, ignored load, held alert.
        begin
            int e, first_alert, done_at;
            logic [HASH_W-1:0] p0;
            p0 = mk_prefix(0) | {8'hA5, {(HASH_W-8){1'b0}}} >> 16;
            first_alert = -1;
            done_at     = -1;
            start_load(p0, ZW'(1));
            e = 0;
            while (done_at < 0 && e < 500) begin
                @(negedge clk);
                e++;
                load_valid = 1'b0;
                if (e == 1) begin
                    chk(pipe_in_valid && busy && !done, "R2 start flags",
                        {pipe_in_valid, busy, done}, 3'b110);
                    chk(pipe_in_data == {p0, {TB_CNT{1'b0}}}, "R2 first seed",
                        pipe_in_data[TB_CNT-1:0], 0);
                end
                if (e == 3) begin
                    load_prefix = '1;
                    load_zeros  = ZW'(5);
                    load_valid  = 1'b1;
                end
                if (e == 5)
                    chk(pipe_in_data == {p0, TB_CNT'(4)}, "R4 load while busy",
                        pipe_in_data[TB_CNT-1:0], 4);
                if (e == 11)
                    chk(pipe_in_data[TB_CNT-1:0] == TB_CNT'(10), "R3 counter step",
                        pipe_in_data[TB_CNT-1:0], 10);
                if (alert && first_alert < 0) begin
                    first_alert = e;
                    chk(alert_nonce == '0, "R5 paired nonce", alert_nonce, 0);
                end
                if (done) done_at = e;
            end
            chk(first_alert == TB_LAT + 2, "R5 alert cycle", first_alert, TB_LAT + 2);
            chk(done_at == DONE_AT, "R10 done cycle", done_at, DONE_AT);
            chk(!busy && !pipe_in_valid, "R3 sweep ended", {busy, pipe_in_valid}, 0);
            chk(alert && alert_nonce == '0, "R8 alert held", alert_nonce, 0);
            alert_ack = 1'b1;
            @(negedge clk);
            alert_ack = 1'b0;
            chk(!alert, "R9 ack clears", alert, 0);
            repeat (4) @(negedge clk);
            chk(done && !busy, "R10 done held", {done, busy}, 2'b10);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule